// File: doc/BRIEF.md
# Safety Switch Debouncer with Status LED

This block keeps a single safety-off flag for an output stage. A push-button is evaluated on a slow sample grid, one evaluation per `TICKS_PER_SAMPLE` pulses of a millisecond tick. When an accepted press is seen on `HOLD_SAMPLES` evaluations in a row, the flag flips. A held button causes one flip only, because the run counter stops at its limit.

Two lock inputs can refuse presses, each in one direction only. A host can also set the flag directly with two single-cycle strobes. A status LED is driven from a 16-step pattern that depends on the flag: it blinks in short bursts while safety is engaged and stays lit while safety is off.

Top module: `safety_switch_ctrl`

## Requirements
- R1: An evaluation happens on the `TICKS_PER_SAMPLE`-th `tick_ms_i` pulse since the previous evaluation or since reset. Clock cycles with `tick_ms_i` low do not count. The button level is used only in evaluation cycles.
- R2: While `safety_off_o` is 1 and `lock_engage_i` is 1, a pressed button at an evaluation is treated as released.
- R3: While `safety_off_o` is 0 and `lock_release_i` is 1, a pressed button at an evaluation is treated as released.
- R4: A run counter goes up by one at each evaluation with an accepted press and is cleared at every other evaluation. The flag toggles at the evaluation where the counter reaches exactly `HOLD_SAMPLES` (default 10).
- R5: The run counter stops at `HOLD_SAMPLES`, so a press held without a break toggles the flag only once.
- R6: A 4-bit step index starts at 0 and goes up by one, modulo 16, at each evaluation. At that evaluation `led_n_o` is loaded with the inverse of bit[step] of the pattern for the new flag value. The pattern is 16'hFFFF when the flag is 1 and 16'h5500 when it is 0. Step is the value after the increment. `led_n_o` changes at no other time.
- R7: A strobe on `force_live_i` sets the flag to 1 on the next edge, and a strobe on `force_safe_i` clears it to 0. A strobe wins over a button toggle in the same cycle. If both strobes are high, `force_safe_i` wins.
- R8: Synchronous reset sets `safety_off_o`=0, `led_n_o`=1, and clears the run counter, the step index and the tick prescaler.
- R9: `safety_off_o` changes only in the cycle after an evaluation or a force strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms_i | input | 1 | One-cycle pulse per millisecond |
| button_i | input | 1 | Push-button level, 1 = pressed |
| lock_engage_i | input | 1 | Refuse presses while safety is off |
| lock_release_i | input | 1 | Refuse presses while safety is on |
| force_safe_i | input | 1 | Strobe: clear flag (safety on) |
| force_live_i | input | 1 | Strobe: set flag (safety off) |
| safety_off_o | output | 1 | 1 = safety off, outputs live |
| led_n_o | output | 1 | Safety LED, active low |

## Verification
The properties assume that every input is synchronous to `clk` and that a force strobe is a level seen on one edge. They do not assume that `tick_ms_i` is periodic.

The stimulus changes inputs only at the falling edge. It spaces the tick pulses irregularly, with idle cycles between them. Between evaluations it drives a changing pattern on the button, so any dependence on the button outside evaluation cycles would show. Force strobes are placed both inside and outside evaluation cycles.

// File: rtl/safety_pkg.sv
package safety_pkg;

    localparam int unsigned LED_STEPS = 16;
    localparam int unsigned STEP_W    = 4;

    localparam logic [LED_STEPS-1:0] PAT_LIVE = 16'hFFFF;
    localparam logic [LED_STEPS-1:0] PAT_SAFE = 16'h5500;

    typedef enum logic {
        ST_SAFE = 1'b0,
        ST_LIVE = 1'b1
    } safety_state_t;

    typedef struct packed {
        logic accepted;
        logic toggle;
    } press_verdict_t;

    function automatic logic [LED_STEPS-1:0] pattern_for(input safety_state_t st);
        return (st == ST_LIVE) ? PAT_LIVE : PAT_SAFE;
    endfunction

    function automatic logic press_allowed(input safety_state_t st,
                                           input logic lock_engage,
                                           input logic lock_release);
        if (st == ST_LIVE) return !lock_engage;
        return !lock_release;
    endfunction

endpackage

// File: rtl/safety_sample_timer.sv
module safety_sample_timer #(
    parameter int unsigned TICKS_PER_SAMPLE = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic eval_o
);
    localparam int unsigned TW = (TICKS_PER_SAMPLE > 2) ? $clog2(TICKS_PER_SAMPLE) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICKS_PER_SAMPLE - 1);

    logic [TW-1:0] tick_cnt;

    assign eval_o = tick_i && (tick_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
        end else if (tick_i) begin
            tick_cnt <= (tick_cnt == LAST) ? '0 : tick_cnt + 1'b1;
        end
    end

    p_eval_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
        eval_o |-> tick_i);

    p_cnt_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(tick_cnt));

endmodule

// File: rtl/safety_press_filter.sv
module safety_press_filter
    import safety_pkg::*;
#(
    parameter int unsigned HOLD_SAMPLES = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           eval_i,
    input  logic           button_i,
    input  safety_state_t  state_i,
    input  logic           lock_engage_i,
    input  logic           lock_release_i,
    output press_verdict_t verdict_o
);
    localparam int unsigned CW = $clog2(HOLD_SAMPLES + 1);
    localparam logic [CW-1:0] HOLD_MAX = CW'(HOLD_SAMPLES);
    localparam logic [CW-1:0] HOLD_PRE = CW'(HOLD_SAMPLES - 1);

    logic [CW-1:0] run_cnt;

    always_comb begin
        verdict_o.accepted = button_i && press_allowed(state_i, lock_engage_i, lock_release_i);
        verdict_o.toggle   = eval_i && verdict_o.accepted && (run_cnt == HOLD_PRE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (eval_i) begin
            if (!verdict_o.accepted)      run_cnt <= '0;
            else if (run_cnt != HOLD_MAX) run_cnt <= run_cnt + 1'b1;
        end
    end

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= HOLD_MAX);

    p_lock_engage_r2: assert property (@(posedge clk) disable iff (rst)
        (eval_i && state_i == ST_LIVE && lock_engage_i) |=> run_cnt == '0);

    p_lock_release_r3: assert property (@(posedge clk) disable iff (rst)
        (eval_i && state_i == ST_SAFE && lock_release_i) |=> run_cnt == '0);

    p_cnt_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !eval_i |=> $stable(run_cnt));

endmodule

// File: rtl/safety_led_sequencer.sv
module safety_led_sequencer
    import safety_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          eval_i,
    input  safety_state_t state_next_i,
    output logic          led_n_o
);
    logic [STEP_W-1:0]    step;
    logic [STEP_W-1:0]    step_next;
    logic [LED_STEPS-1:0] pat;

    always_comb begin
        step_next = step + 1'b1;
        pat       = pattern_for(state_next_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step    <= '0;
            led_n_o <= 1'b1;
        end else if (eval_i) begin
            step    <= step_next;
            led_n_o <= ~pat[step_next];
        end
    end

    p_step_adv_r6: assert property (@(posedge clk) disable iff (rst)
        eval_i |=> step == STEP_W'($past(step) + 1'b1));

    p_led_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !eval_i |=> $stable(led_n_o));

endmodule

// File: rtl/safety_switch_ctrl.sv
module safety_switch_ctrl
    import safety_pkg::*;
#(
    parameter int unsigned TICKS_PER_SAMPLE = 100,
    parameter int unsigned HOLD_SAMPLES     = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_ms_i,
    input  logic button_i,
    input  logic lock_engage_i,
    input  logic lock_release_i,
    input  logic force_safe_i,
    input  logic force_live_i,
    output logic safety_off_o,
    output logic led_n_o
);
    logic           eval;
    press_verdict_t verdict;
    safety_state_t  state_q;
    safety_state_t  state_d;

    safety_sample_timer #(.TICKS_PER_SAMPLE(TICKS_PER_SAMPLE)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_ms_i),
        .eval_o (eval)
    );

    safety_press_filter #(.HOLD_SAMPLES(HOLD_SAMPLES)) filter_i (
        .clk            (clk),
        .rst            (rst),
        .eval_i         (eval),
        .button_i       (button_i),
        .state_i        (state_q),
        .lock_engage_i  (lock_engage_i),
        .lock_release_i (lock_release_i),
        .verdict_o      (verdict)
    );

    always_comb begin
        state_d = state_q;
        if (verdict.toggle) begin
            state_d = (state_q == ST_LIVE) ? ST_SAFE : ST_LIVE;
        end
        if (force_safe_i)      state_d = ST_SAFE;
        else if (force_live_i) state_d = ST_LIVE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SAFE;
        else     state_q <= state_d;
    end

    safety_led_sequencer led_i (
        .clk          (clk),
        .rst          (rst),
        .eval_i       (eval),
        .state_next_i (state_d),
        .led_n_o      (led_n_o)
    );

    assign safety_off_o = (state_q == ST_LIVE);

    p_flag_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (!eval && !force_safe_i && !force_live_i) |=> $stable(safety_off_o));

    p_force_safe_r7: assert property (@(posedge clk) disable iff (rst)
        force_safe_i |=> !safety_off_o);

    p_force_live_r7: assert property (@(posedge clk) disable iff (rst)
        (force_live_i && !force_safe_i) |=> safety_off_o);

    p_led_live_r6: assert property (@(posedge clk) disable iff (rst)
        (eval && state_d == ST_LIVE) |=> !led_n_o);

endmodule

// File: tb/safety_switch_ctrl_tb_top.sv
module safety_switch_ctrl_tb_top;
    localparam int TPS  = 100;
    localparam int HOLD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 0, btn = 0, lk_eng = 0, lk_rel = 0, f_safe = 0, f_live = 0;
    logic safety_off, led_n;

    always #4 clk = ~clk;

    safety_switch_ctrl #(.TICKS_PER_SAMPLE(TPS), .HOLD_SAMPLES(HOLD)) dut_i (
        .clk(clk), .rst(rst), .tick_ms_i(tick), .button_i(btn),
        .lock_engage_i(lk_eng), .lock_release_i(lk_rel),
        .force_safe_i(f_safe), .force_live_i(f_live),
        .safety_off_o(safety_off), .led_n_o(led_n));

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // reference state
    int  m_cnt = 0;
    bit  m_live = 0;
    int  m_step = 0;
    bit  m_led = 1;
    int  noise = 7;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic bit pat_bit(input bit live, input int idx);
        logic [15:0] p;
        p = live ? 16'hFFFF : 16'h5500;
        return p[idx];
    endfunction

    // one evaluation: TPS ticks with gaps, noisy button, final button level b
    task automatic sample(input bit b, input bit fs, input bit fl);
        bit acc, tog;
        for (int i = 0; i < TPS; i++) begin
            if (i % 7 == 3) begin
                tick = 0;
                btn  = ~b;
                @(negedge clk);
            end
            noise = (noise * 13 + 5) % 64;
            tick = 1;
            btn  = (i == TPS - 1) ? b : noise[2];
            if (i == TPS - 1) begin
                f_safe = fs;
                f_live = fl;
            end
            @(negedge clk);
            f_safe = 0;
            f_live = 0;
            if (i == TPS - 2) begin
                check("R1 no early change", safety_off, m_live);
                check("R6 led held", led_n, m_led);
            end
        end
        tick = 0;
        btn  = 0;
        acc = b && !(m_live && lk_eng) && !(!m_live && lk_rel);
        tog = 0;
        if (acc) begin
            if (m_cnt == HOLD - 1) tog = 1;
            if (m_cnt < HOLD) m_cnt++;
        end else begin
            m_cnt = 0;
        end
        if (tog) m_live = !m_live;
        if (fs)      m_live = 0;
        else if (fl) m_live = 1;
        m_step = (m_step + 1) % 16;
        m_led  = !pat_bit(m_live, m_step);
        check("R4 flag", safety_off, m_live);
        check("R6 led", led_n, m_led);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R8 reset flag", safety_off, 1'b0);
        check("R8 reset led", led_n, 1'b1);

        // R2 R3 R4 R5 sweep: all lock combos, hold lengths 1..13
        for (int m = 0; m < 4; m++) begin
            lk_eng = m[0];
            lk_rel = m[1];
            for (int h = 1; h <= 13; h++) begin
                for (int k = 0; k < h; k++) sample(1'b1, 1'b0, 1'b0);
                sample(1'b0, 1'b0, 1'b0);
            end
        end
        lk_eng = 0;
        lk_rel = 0;

        // R7 force outside evaluation
        f_live = 1;
        @(negedge clk);
        f_live = 0;
        m_live = 1;
        check("R7 force live", safety_off, 1'b1);
        check("R7 led unchanged", led_n, m_led);
        f_safe = 1;
        f_live = 1;
        @(negedge clk);
        f_safe = 0;
        f_live = 0;
        m_live = 0;
        check("R7 both strobes", safety_off, 1'b0);

        // R7 force against a toggle in the same evaluation
        for (int k = 0; k < HOLD - 1; k++) sample(1'b1, 1'b0, 1'b0);
        sample(1'b1, 1'b1, 1'b0);
        check("R7 force beats toggle", safety_off, 1'b0);
        sample(1'b0, 1'b0, 1'b0);
        m_live = 0;

        // R5 long hold toggles once
        for (int k = 0; k < 3 * HOLD; k++) sample(1'b1, 1'b0, 1'b0);
        check("R5 single toggle", safety_off, 1'b1);
        sample(1'b0, 1'b0, 1'b0);

        // R8 reset mid-state
        rst = 1;
        @(negedge clk);
        rst = 0;
        m_cnt = 0; m_live = 0; m_step = 0; m_led = 1;
        check("R8 re-reset flag", safety_off, 1'b0);
        check("R8 re-reset led", led_n, 1'b1);
        for (int k = 0; k < HOLD; k++) sample(1'b1, 1'b0, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule